// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a host reach a private bank of 16-bit configuration registers that are not mapped into the host's address space. The host sees only four 32-bit window words, selected by a two-bit word index. These are an address word, a write-data word, a command word and a status word. Writing a command launches one transaction on an internal request/response port towards the bank. The host then polls the status word until a ready flag appears. The status word also carries a two-bit completion code and, for a successful read, the 16-bit register value.

The address word carries the target halfword address in its low 16 bits. Bits 19:16 must hold the tag value 0x3, or the request is refused without reaching the bank. Command value 1 writes and command value 2 reads. Other command values, and any command issued while a transaction is still in flight, are dropped. If the bank stays silent, an internal timeout ends the transaction with a "no response" code. The host can therefore always stop polling after a bounded number of reads.

The register bank is modelled inside the block. Halfword addresses below `DEPTH` hold real registers and answer after `LAT` cycles. Addresses from `DEPTH` up to `2*DEPTH` answer with an error. Addresses at or above `2*DEPTH` never answer.

Top module: `ibr_bridge`

## Requirements
- R1: After reset the address word, the write-data word and the status word read 0, and every bank register reads back as 0x0000 through a read command.
- R2: Window word index 0 is the address word and index 1 is the write-data word. Both read back as the full 32 bits last written. Index 2 (command) reads 0. In index 3 (status), bits 31:19 read 0. `host_req_rdy` is always 1, and every accepted read returns `host_rsp_vld` with its data in the following cycle.
- R3: Writing 1 to the command word stores write-data bits 15:0 into bank register (address bits 15:0). The transaction then completes with ready=1 and status 01.
- R4: Writing 2 to the command word reads bank register (address bits 15:0). On completion, the status word has bit 18 = 1, bits 17:16 = 01 and bits 15:0 = the register value.
- R5: An accepted command clears the ready flag and the status field from the next cycle on, so a status read right after a valid-tag command returns 0.
- R6: If address bits 19:16 are not 0x3, the command completes with ready=1 and status 10 (status word 0x0006_0000), and the bank is left unchanged.
- R7: A halfword address from DEPTH to 2*DEPTH-1 completes with status 11 (status word 0x0007_0000).
- R8: A halfword address of 2*DEPTH or more gets no answer. Exactly TIMEOUT cycles (default 16) after the request, the block completes with ready=1 and status 00 (status word 0x0004_0000).
- R9: Command values other than 1 and 2 are ignored, and so is any command written while a transaction is in flight. Neither changes the status word or the bank.
- R10: Bits 15:0 of the status word are 0 unless the completed transaction was a read with status 01.
- R11: Only address bits 15:0 select the bank register, and each register is distinct: writing one halfword address leaves its neighbours unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req_vld | input | 1 | Host request valid |
| host_req_rdy | output | 1 | Host request ready (always 1) |
| host_req_wr | input | 1 | 1 = write window word, 0 = read |
| host_req_addr | input | 2 | Window word index |
| host_req_wdata | input | 32 | Host write data |
| host_rsp_vld | output | 1 | Read response valid, one cycle after the request |
| host_rsp_rdata | output | 32 | Read response data |

## Verification
The bank is exercised with good-tag reads and writes to several halfword addresses, and neighbouring registers are read back. This separates correct address selection from aliasing, and separates write data landing in the bank from data merely echoed back. Addresses are also chosen on each side of DEPTH and of 2*DEPTH, and an address is given a wrong tag. Each of these must produce its own completion code, which tells the four status paths apart, and reads of the bank afterwards show that refused and ignored requests wrote nothing. Some status reads are issued straight after a command, and some commands are issued while a silent transaction is pending. These distinguish the clearing of ready from stale completion, and the busy lockout from a second launch.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
    localparam int DATA_W = 32;
    localparam int HW_W   = 16;
    localparam int WIN_AW = 2;
    localparam int ADDR_KEEP_W = 20;

    localparam logic [WIN_AW-1:0] WIN_ADDR  = 2'd0;
    localparam logic [WIN_AW-1:0] WIN_WDATA = 2'd1;
    localparam logic [WIN_AW-1:0] WIN_CMD   = 2'd2;
    localparam logic [WIN_AW-1:0] WIN_STAT  = 2'd3;

    localparam logic [DATA_W-1:0] CMD_WR = 32'd1;
    localparam logic [DATA_W-1:0] CMD_RD = 32'd2;
    localparam logic [3:0]        OFS_TAG = 4'h3;

    typedef enum logic [1:0] {
        STS_NORESP  = 2'b00,
        STS_OK      = 2'b01,
        STS_REQFAIL = 2'b10,
        STS_RSPERR  = 2'b11
    } sts_e;

    typedef struct packed {
        logic            wr;
        logic [HW_W-1:0] haddr;
        logic [HW_W-1:0] wdata;
    } be_req_t;

    typedef struct packed {
        logic            err;
        logic [HW_W-1:0] rdata;
    } be_rsp_t;

    typedef struct packed {
        logic            ready;
        sts_e            sts;
        logic [HW_W-1:0] data;
    } result_t;

    function automatic logic [DATA_W-1:0] pack_status(input result_t r);
        return {13'd0, r.ready, r.sts, r.data};
    endfunction

    function automatic logic tag_ok(input logic [ADDR_KEEP_W-1:0] a);
        return a[19:16] == OFS_TAG;
    endfunction

    function automatic logic cmd_known(input logic [DATA_W-1:0] v);
        return (v == CMD_WR) || (v == CMD_RD);
    endfunction
endpackage

// File: rtl/ibr_window.sv
module ibr_window
    import ibr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req_vld,
    input  logic              host_req_wr,
    input  logic [WIN_AW-1:0] host_req_addr,
    input  logic [DATA_W-1:0] host_req_wdata,
    output logic              host_rsp_vld,
    output logic [DATA_W-1:0] host_rsp_rdata,
    input  logic              busy,
    input  result_t           res,
    output logic [DATA_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              launch,
    output logic              launch_rd
);
    logic              wr_acc;
    logic              rd_acc;
    logic [DATA_W-1:0] rd_mux;

    assign wr_acc    = host_req_vld && host_req_wr;
    assign rd_acc    = host_req_vld && !host_req_wr;
    assign launch    = wr_acc && (host_req_addr == WIN_CMD) && !busy
                       && cmd_known(host_req_wdata);
    assign launch_rd = (host_req_wdata == CMD_RD);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (wr_acc) begin
            if (host_req_addr == WIN_ADDR)  addr_q  <= host_req_wdata;
            if (host_req_addr == WIN_WDATA) wdata_q <= host_req_wdata;
        end
    end

    always_comb begin
        case (host_req_addr)
            WIN_ADDR:  rd_mux = addr_q;
            WIN_WDATA: rd_mux = wdata_q;
            WIN_STAT:  rd_mux = pack_status(res);
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            host_rsp_vld   <= 1'b0;
            host_rsp_rdata <= '0;
        end else begin
            host_rsp_vld <= rd_acc;
            if (rd_acc) host_rsp_rdata <= rd_mux;
        end
    end

    // R2: every accepted read is answered in the next cycle
    assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (rst)
        rd_acc |=> host_rsp_vld);
endmodule

// File: rtl/ibr_seq.sv
module ibr_seq
    import ibr_pkg::*;
#(
    parameter int TIMEOUT = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   launch,
    input  logic                   launch_rd,
    input  logic [ADDR_KEEP_W-1:0] addr_in,
    input  logic [HW_W-1:0]        wdata_in,
    output logic                   be_req_vld,
    output be_req_t                be_req,
    input  logic                   be_rsp_vld,
    input  be_rsp_t                be_rsp,
    output result_t                res,
    output logic                   busy
);
    localparam int TMO_W = $clog2(TIMEOUT + 1);
    localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TIMEOUT - 1);

    typedef enum logic {S_IDLE, S_WAIT} state_e;
    state_e           state;
    logic [TMO_W-1:0] tmo;

    assign busy = (state != S_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            tmo        <= '0;
            be_req_vld <= 1'b0;
            be_req     <= '0;
            res        <= '{ready: 1'b0, sts: STS_NORESP, data: '0};
        end else begin
            be_req_vld <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (launch) begin
                        if (!tag_ok(addr_in)) begin
                            res <= '{ready: 1'b1, sts: STS_REQFAIL, data: '0};
                        end else begin
                            res        <= '{ready: 1'b0, sts: STS_NORESP, data: '0};
                            be_req_vld <= 1'b1;
                            be_req     <= '{wr: !launch_rd, haddr: addr_in[HW_W-1:0],
                                            wdata: wdata_in};
                            tmo        <= '0;
                            state      <= S_WAIT;
                        end
                    end
                end
                default: begin
                    if (be_rsp_vld) begin
                        res.ready <= 1'b1;
                        res.sts   <= be_rsp.err ? STS_RSPERR : STS_OK;
                        res.data  <= (!be_rsp.err && !be_req.wr) ? be_rsp.rdata : '0;
                        state     <= S_IDLE;
                    end else if (tmo == TMO_LAST) begin
                        res   <= '{ready: 1'b1, sts: STS_NORESP, data: '0};
                        state <= S_IDLE;
                    end else begin
                        tmo <= tmo + 1'b1;
                    end
                end
            endcase
        end
    end

    // R5: a launch clears ready unless it is refused at once
    assert_clear_on_launch_R5: assert property (@(posedge clk) disable iff (rst)
        launch |=> (!res.ready || res.sts == STS_REQFAIL));
    // R6: a bad tag never produces a bank request
    assert_badtag_no_req_R6: assert property (@(posedge clk) disable iff (rst)
        (launch && !tag_ok(addr_in)) |=> !be_req_vld);
    // R8: the wait counter stays inside the timeout window
    assert_timeout_bound_R8: assert property (@(posedge clk) disable iff (rst)
        (state == S_WAIT) |-> (tmo <= TMO_LAST));
    // R3: bank requests are single-cycle pulses
    assert_req_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        be_req_vld |=> !be_req_vld);
    // R10: data field is zero on any non-OK completion
    assert_data_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (res.ready && res.sts != STS_OK) |-> (res.data == '0));
endmodule

// File: rtl/ibr_bank.sv
module ibr_bank
    import ibr_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LAT   = 3
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    req_vld,
    input  be_req_t req,
    output logic    rsp_vld,
    output be_rsp_t rsp
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int LAT_W = $clog2(LAT + 1);
    localparam logic [HW_W-1:0] LIM_OK  = HW_W'(DEPTH);
    localparam logic [HW_W-1:0] LIM_ERR = HW_W'(2 * DEPTH);

    logic [HW_W-1:0]  mem [DEPTH];
    logic [IDX_W-1:0] idx;
    logic             in_ok;
    logic             answers;
    logic [LAT_W-1:0] cnt;

    assign idx     = req.haddr[IDX_W-1:0];
    assign in_ok   = req.haddr < LIM_OK;
    assign answers = req.haddr < LIM_ERR;

    for (genvar g = 0; g < DEPTH; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                mem[g] <= '0;
            else if (req_vld && req.wr && in_ok && idx == IDX_W'(g))
                mem[g] <= req.wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            rsp_vld <= 1'b0;
            rsp     <= '0;
        end else begin
            rsp_vld <= 1'b0;
            if (req_vld && answers) begin
                cnt       <= LAT_W'(LAT);
                rsp.err   <= !in_ok;
                rsp.rdata <= (in_ok && !req.wr) ? mem[idx] : '0;
            end else if (cnt != '0) begin
                cnt     <= cnt - 1'b1;
                rsp_vld <= (cnt == LAT_W'(1));
            end
        end
    end

    // R7: error responses carry no data
    assert_err_nodata_R7: assert property (@(posedge clk) disable iff (rst)
        (rsp_vld && rsp.err) |-> (rsp.rdata == '0));
endmodule

// File: rtl/ibr_bridge.sv
module ibr_bridge
    import ibr_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int LAT     = 3,
    parameter int TIMEOUT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req_vld,
    output logic              host_req_rdy,
    input  logic              host_req_wr,
    input  logic [WIN_AW-1:0] host_req_addr,
    input  logic [DATA_W-1:0] host_req_wdata,
    output logic              host_rsp_vld,
    output logic [DATA_W-1:0] host_rsp_rdata
);
    logic [DATA_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              launch;
    logic              launch_rd;
    logic              busy;
    result_t           res;
    logic              be_req_vld;
    be_req_t           be_req;
    logic              be_rsp_vld;
    be_rsp_t           be_rsp;

    assign host_req_rdy = 1'b1;

    ibr_window u_window (
        .clk            (clk),
        .rst            (rst),
        .host_req_vld   (host_req_vld),
        .host_req_wr    (host_req_wr),
        .host_req_addr  (host_req_addr),
        .host_req_wdata (host_req_wdata),
        .host_rsp_vld   (host_rsp_vld),
        .host_rsp_rdata (host_rsp_rdata),
        .busy           (busy),
        .res            (res),
        .addr_q         (addr_q),
        .wdata_q        (wdata_q),
        .launch         (launch),
        .launch_rd      (launch_rd)
    );

    ibr_seq #(.TIMEOUT(TIMEOUT)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .launch     (launch),
        .launch_rd  (launch_rd),
        .addr_in    (addr_q[ADDR_KEEP_W-1:0]),
        .wdata_in   (wdata_q[HW_W-1:0]),
        .be_req_vld (be_req_vld),
        .be_req     (be_req),
        .be_rsp_vld (be_rsp_vld),
        .be_rsp     (be_rsp),
        .res        (res),
        .busy       (busy)
    );

    ibr_bank #(.DEPTH(DEPTH), .LAT(LAT)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .req_vld (be_req_vld),
        .req     (be_req),
        .rsp_vld (be_rsp_vld),
        .rsp     (be_rsp)
    );

    // R6: a bank request only follows a window address carrying the 0x3 tag
    assert_req_tag_R6: assert property (@(posedge clk) disable iff (rst)
        be_req_vld |-> ($past(addr_q[19:16]) == OFS_TAG));
endmodule

// File: tb/test_ibr_bridge.sv
module test_ibr_bridge;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req_vld = 1'b0;
    logic        host_req_rdy;
    logic        host_req_wr = 1'b0;
    logic [1:0]  host_req_addr = 2'd0;
    logic [31:0] host_req_wdata = 32'd0;
    logic        host_rsp_vld;
    logic [31:0] host_rsp_rdata;

    always #5 clk = ~clk;

    ibr_bridge i_ibr_bridge (.*);

    typedef struct {
        bit          chk;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;

    localparam logic [1:0] W_ADDR = 2'd0, W_WDATA = 2'd1, W_CMD = 2'd2, W_STAT = 2'd3;

    // monitor: pops the scoreboard on each read response
    always @(negedge clk) begin
        if (!rst && host_rsp_vld) begin
            if (sb_q.size() == 0) begin
                errors++;
                $display("FAIL R2 unexpected response act=%h exp=none", host_rsp_rdata);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                if (it.chk) begin
                    checks++;
                    if (host_rsp_rdata !== it.exp) begin
                        errors++;
                        $display("FAIL %s act=%h exp=%h", it.tag, host_rsp_rdata, it.exp);
                    end
                end
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        host_req_vld = 1'b1; host_req_wr = 1'b1; host_req_addr = a; host_req_wdata = d;
        @(negedge clk);
        host_req_vld = 1'b0; host_req_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input bit chk, input logic [31:0] exp,
                      input string tag, output logic [31:0] got);
        item_t it;
        it.chk = chk; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        host_req_vld = 1'b1; host_req_wr = 1'b0; host_req_addr = a;
        @(negedge clk);
        host_req_vld = 1'b0;
        got = host_rsp_rdata;
    endtask

    task automatic expect_rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] v;
        rd(a, 1'b1, exp, tag, v);
    endtask

    task automatic poll();
        logic [31:0] v;
        for (int i = 0; i < 32; i++) begin
            rd(W_STAT, 1'b0, 32'd0, "", v);
            if (v[18]) break;
        end
    endtask

    task automatic do_cmd(input logic [31:0] addr, input logic [31:0] data, input logic [31:0] cmd);
        wr(W_ADDR, addr);
        wr(W_WDATA, data);
        wr(W_CMD, cmd);
    endtask

    // bank readback helper: read command then checked status
    task automatic bank_check(input logic [15:0] haddr, input logic [15:0] exp, input string tag);
        do_cmd({16'h0003, haddr}, 32'd0, 32'd2);
        poll();
        expect_rd(W_STAT, {13'd0, 1'b1, 2'b01, exp}, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog act=hung exp=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        checks++;
        if (host_req_rdy !== 1'b1) begin
            errors++;
            $display("FAIL R2 rdy act=%b exp=1", host_req_rdy);
        end
        expect_rd(W_ADDR,  32'h0, "R1 addr word after reset");
        expect_rd(W_WDATA, 32'h0, "R1 wdata word after reset");
        expect_rd(W_STAT,  32'h0, "R1 status word after reset");
        bank_check(16'h0000, 16'h0000, "R1 bank reg 0 after reset");

        // R2 window readback
        wr(W_ADDR, 32'hFED3_0005);
        expect_rd(W_ADDR, 32'hFED3_0005, "R2 addr word readback");
        wr(W_WDATA, 32'hABCD_1234);
        expect_rd(W_WDATA, 32'hABCD_1234, "R2 wdata word readback");
        expect_rd(W_CMD, 32'h0, "R2 cmd word reads zero");

        // R3 / R10 write transaction
        do_cmd(32'h0003_0005, 32'hABCD_BEEF, 32'd1);
        poll();
        expect_rd(W_STAT, 32'h0005_0000, "R3 R10 write completes OK with zero data");
        // R4 read back
        bank_check(16'h0005, 16'hBEEF, "R4 read returns written value");

        // R11 neighbour distinct
        do_cmd(32'h0003_0006, 32'h0000_1234, 32'd1);
        poll();
        bank_check(16'h0005, 16'hBEEF, "R11 neighbour reg 5 unchanged");
        do_cmd(32'h0003_000F, 32'h0000_5A5A, 32'd1);
        poll();
        bank_check(16'h000F, 16'h5A5A, "R11 top reg of bank");

        // R5 clear on new command
        do_cmd(32'h0003_0006, 32'd0, 32'd2);
        expect_rd(W_STAT, 32'h0, "R5 status cleared right after command");
        poll();
        expect_rd(W_STAT, 32'h0005_1234, "R4 read reg 6");

        // R6 bad tag
        do_cmd(32'h0002_0005, 32'h0000_1111, 32'd1);
        poll();
        expect_rd(W_STAT, 32'h0006_0000, "R6 bad tag write refused");
        do_cmd(32'h0000_0005, 32'd0, 32'd2);
        poll();
        expect_rd(W_STAT, 32'h0006_0000, "R6 zero tag read refused");
        bank_check(16'h0005, 16'hBEEF, "R6 bank untouched by refused write");

        // R7 error region
        do_cmd(32'h0003_0010, 32'd0, 32'd2);
        poll();
        expect_rd(W_STAT, 32'h0007_0000, "R7 low edge of error region");
        do_cmd(32'h0003_001F, 32'h0000_2222, 32'd1);
        poll();
        expect_rd(W_STAT, 32'h0007_0000, "R7 high edge of error region");

        // R8 silent region timeout
        do_cmd(32'h0003_0020, 32'd0, 32'd2);
        expect_rd(W_STAT, 32'h0, "R8 not ready early in timeout window");
        poll();
        expect_rd(W_STAT, 32'h0004_0000, "R8 timeout gives ready with status 00");

        // R9 unknown command ignored
        wr(W_CMD, 32'd3);
        expect_rd(W_STAT, 32'h0004_0000, "R9 cmd 3 leaves status");
        wr(W_CMD, 32'd0);
        expect_rd(W_STAT, 32'h0004_0000, "R9 cmd 0 leaves status");

        // R9 command while busy ignored
        do_cmd(32'h0003_0040, 32'd0, 32'd2);
        do_cmd(32'h0003_0005, 32'h0000_7777, 32'd1);
        poll();
        expect_rd(W_STAT, 32'h0004_0000, "R9 busy command dropped, timeout kept");
        bank_check(16'h0005, 16'hBEEF, "R9 busy write never reached bank");

        repeat (4) @(negedge clk);
        if (sb_q.size() != 0) begin
            errors++;
            checks++;
            $display("FAIL R2 missing responses act=%0d exp=0", sb_q.size());
        end
        finish_run();
    end
endmodule